// File: doc/BRIEF.md
# Credit-Gated Wormhole Link Sender

This block drives the outgoing side of one router-to-router link in a wormhole on-chip network. A local flit buffer offers flits through a valid/ready handshake. Each flit is passed downstream in the same cycle it is offered, but only while a credit shows that the next-hop router has a free buffer slot. A one-cycle pulse on the credit-return input means the downstream router has freed one slot.

The sender keeps a credit count that starts at the downstream buffer depth. Each forwarded flit takes one credit and each return gives one back. When the count is zero the sender holds the local buffer off with ready low, so no flit is ever discarded. A packet moves as a worm: its body flits go out as they arrive, without the whole packet first being gathered. A lock output marks the link as held by one packet from its head flit through its tail flit.

Each flit is as wide as the link (128 bits by default). Its two most significant bits give the flit kind. The head flit carries the destination in its payload, and this block passes that payload through unchanged.

Top module: `link_sender`

## Requirements
- R1: After reset the credit count equals the downstream depth (parameter `DEPTH`, default 4), `in_ready` is 1, `link_locked` is 0 and `out_valid` is 0.
- R2: Flits leave in the order they are accepted, and `out_flit` carries the offered flit unchanged in the cycle it is forwarded.
- R3: `in_ready` is 1 exactly when the credit count is nonzero, whatever the value of `in_valid`.
- R4: Each forwarded flit with no credit return in the same cycle lowers the count by one. After `DEPTH` forwards with no returns, `in_ready` is 0.
- R5: A credit-return pulse with no forward in the same cycle raises the count by one, so a stalled sender becomes ready in the next cycle.
- R6: A forward and a credit return in the same cycle leave the count unchanged.
- R7: `out_valid` equals `in_valid` AND credit available. At zero credits an offered flit is held at the input and is not dropped.
- R8: The count never exceeds `DEPTH`. A credit return while the count is already `DEPTH` and nothing is forwarded is ignored.
- R9: The flit kind is held in bits [W-1:W-2]: 00 body, 01 head, 10 tail, 11 single (head and tail). Forwarding a head flit sets `link_locked`, and `link_locked` stays set through the body flits until a tail flit is forwarded, which clears it.
- R10: Forwarding a single flit (kind 11) leaves `link_locked` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Local buffer offers a flit |
| in_flit | input | FLIT_W | Offered flit; top two bits give the kind |
| in_ready | output | 1 | Credit available; the offered flit is taken at the clock edge |
| out_valid | output | 1 | Flit is placed on the link this cycle |
| out_flit | output | FLIT_W | Flit on the link |
| credit_ret | input | 1 | One-cycle pulse: downstream freed one slot |
| link_locked | output | 1 | Link held by a packet between head and tail |

## Verification
The assertions assume that the downstream router never returns more credits than flits it has received. Under that assumption the count stays within range without relying on saturation. They also assume that the local buffer sends packets in a well-formed kind order. The stimulus sends complete head-body-tail packets and single flits. It returns credits only after flits have been sent, except in one deliberate test of R8, where extra returns are issued at full count and the only check is that they are ignored. Inputs change only just after a rising edge, so credit returns and flit offers can coincide in the same cycle without any race.

// File: rtl/link_sender_pkg.sv
package link_sender_pkg;

   typedef enum logic [1:0] {
      FK_BODY   = 2'b00,
      FK_HEAD   = 2'b01,
      FK_TAIL   = 2'b10,
      FK_SINGLE = 2'b11
   } flit_kind_e;

   // bit 0 opens a packet, bit 1 closes it
   function automatic logic kind_opens(input flit_kind_e k);
      return k[0];
   endfunction

   function automatic logic kind_closes(input flit_kind_e k);
      return k[1];
   endfunction

endpackage

// File: rtl/link_credit_ctr.sv
module link_credit_ctr #(
   parameter int DEPTH  = 4,
   parameter bit BYPASS = 1'b0,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          give,
   output logic [CW-1:0] count,
   output logic          avail
);

   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic [CW-1:0] count_q;
   logic [CW-1:0] count_d;

   always_comb begin
      count_d = count_q;
      unique case ({take, give})
         2'b10:   count_d = count_q - 1'b1;
         2'b01:   count_d = (count_q == FULL) ? count_q : count_q + 1'b1;
         default: count_d = count_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) count_q <= FULL;
      else        count_q <= count_d;
   end

   generate
      if (BYPASS) begin : g_bypass
         assign avail = (count_q != '0) || give;
      end else begin : g_registered
         assign avail = (count_q != '0);
      end
   endgenerate

   assign count = count_q;

endmodule

// File: rtl/link_pkt_lock.sv
module link_pkt_lock
   import link_sender_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fire,
   input  flit_kind_e kind,
   output logic       locked
);

   logic locked_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
      end else if (fire) begin
         if (kind_closes(kind))     locked_q <= 1'b0;
         else if (kind_opens(kind)) locked_q <= 1'b1;
      end
   end

   assign locked = locked_q;

endmodule

// File: rtl/link_fwd_gate.sv
module link_fwd_gate
   import link_sender_pkg::*;
#(
   parameter int FLIT_W = 128
) (
   input  logic              in_valid,
   input  logic [FLIT_W-1:0] in_flit,
   input  logic              avail,
   output logic              in_ready,
   output logic              out_valid,
   output logic [FLIT_W-1:0] out_flit,
   output logic              fire,
   output flit_kind_e        kind
);

   assign in_ready  = avail;
   assign fire      = in_valid && avail;
   assign out_valid = fire;
   assign out_flit  = in_flit;
   assign kind      = flit_kind_e'(in_flit[FLIT_W-1 -: 2]);

endmodule

// File: rtl/link_sender.sv
module link_sender
   import link_sender_pkg::*;
#(
   parameter int FLIT_W = 128,
   parameter int DEPTH  = 4,
   parameter bit BYPASS = 1'b0,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [FLIT_W-1:0] in_flit,
   output logic              in_ready,
   output logic              out_valid,
   output logic [FLIT_W-1:0] out_flit,
   input  logic              credit_ret,
   output logic              link_locked
);

   generate
      if (FLIT_W < 3) begin : g_bad_width
         $error("link_sender: FLIT_W must leave room for kind and payload");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("link_sender: DEPTH must be at least one");
      end
   endgenerate

   logic          avail;
   logic          fire;
   flit_kind_e    kind;
   logic [CW-1:0] credit_cnt;

   link_fwd_gate #(.FLIT_W(FLIT_W)) u_gate (
      .in_valid (in_valid),
      .in_flit  (in_flit),
      .avail    (avail),
      .in_ready (in_ready),
      .out_valid(out_valid),
      .out_flit (out_flit),
      .fire     (fire),
      .kind     (kind)
   );

   link_credit_ctr #(.DEPTH(DEPTH), .BYPASS(BYPASS)) u_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .take (fire),
      .give (credit_ret),
      .count(credit_cnt),
      .avail(avail)
   );

   link_pkt_lock u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .kind  (kind),
      .locked(link_locked)
   );

endmodule

// File: rtl/link_sender_chk.sv
module link_sender_chk #(
   parameter int FLIT_W = 128,
   parameter int DEPTH  = 4,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [FLIT_W-1:0] in_flit,
   input logic              in_ready,
   input logic              out_valid,
   input logic              credit_ret,
   input logic              link_locked,
   input logic [CW-1:0]     credit_cnt
);

   localparam logic [CW-1:0] FULL = CW'(DEPTH);
   logic [1:0] kind;
   assign kind = in_flit[FLIT_W-1 -: 2];

   // R7
   stall_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && credit_cnt == '0 && !credit_ret) |-> !out_valid);

   // R3
   ready_needs_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (credit_cnt != '0 || credit_ret));

   // R4
   debit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !credit_ret) |=> credit_cnt == CW'($past(credit_cnt) - 1'b1));

   // R5
   refund_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid && credit_ret && credit_cnt < FULL) |=> credit_cnt == CW'($past(credit_cnt) + 1'b1));

   // R6
   balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && credit_ret) |=> $stable(credit_cnt));

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      credit_cnt <= FULL);

   // R9
   lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && kind == 2'b01) |=> link_locked);

   // R9
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_locked && !(out_valid && kind[1])) |=> link_locked);

   // R10
   lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && kind[1]) |=> !link_locked);

endmodule

bind link_sender link_sender_chk #(.FLIT_W(FLIT_W), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_flit    (in_flit),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .credit_ret (credit_ret),
   .link_locked(link_locked),
   .credit_cnt (credit_cnt)
);

// File: tb/link_sender_bench.sv
module link_sender_bench;

   localparam int PERIOD = 10;
   localparam int W      = 128;
   localparam int DEPTH  = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_flit = '0;
   logic         in_ready;
   logic         out_valid;
   logic [W-1:0] out_flit;
   logic         credit_ret = 1'b0;
   logic         link_locked;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] exp_q[$];
   int  exp_cred;
   logic exp_lock;

   always #(PERIOD/2) clk = ~clk;

   link_sender #(.FLIT_W(W), .DEPTH(DEPTH)) u_link_sender (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
      .in_ready(in_ready), .out_valid(out_valid), .out_flit(out_flit),
      .credit_ret(credit_ret), .link_locked(link_locked)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [W-1:0] mk(input logic [1:0] k, input int tag);
      return {k, (W-2)'(tag)};
   endfunction

   // monitor with a bench-side credit and lock model
   always @(negedge clk) begin
      if (!rst_n) begin
         exp_cred = DEPTH;
         exp_lock = 1'b0;
      end else begin
         logic rdy;
         logic snd;
         logic [W-1:0] e;
         rdy = (exp_cred != 0);
         snd = in_valid && rdy;
         check(in_ready == rdy, "R3", "in_ready", W'(in_ready), W'(rdy));
         check(out_valid == snd, "R7", "out_valid", W'(out_valid), W'(snd));
         check(link_locked == exp_lock, "R9", "link_locked", W'(link_locked), W'(exp_lock));
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2", "unexpected flit", out_flit, '0);
            end else begin
               e = exp_q.pop_front();
               check(out_flit == e, "R2", "out_flit", out_flit, e);
            end
         end
         if (snd) begin
            if (in_flit[W-1]) exp_lock = 1'b0;
            else if (in_flit[W-2]) exp_lock = 1'b1;
         end
         if (snd && !credit_ret) exp_cred = exp_cred - 1;
         else if (!snd && credit_ret && exp_cred < DEPTH) exp_cred = exp_cred + 1;
      end
   end

   // driver: call just after a rising edge
   task automatic send(input logic [W-1:0] f);
      in_valid = 1'b1;
      in_flit  = f;
      exp_q.push_back(f);
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic pulse_credits(input int n);
      for (int i = 0; i < n; i++) begin
         credit_ret = 1'b1;
         @(posedge clk); #1;
      end
      credit_ret = 1'b0;
   endtask

   initial begin
      #(PERIOD * 20000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(in_ready == 1'b1, "R1", "ready after reset", W'(in_ready), 1);
      check(link_locked == 1'b0, "R1", "lock after reset", W'(link_locked), 0);
      check(out_valid == 1'b0, "R1", "out_valid after reset", W'(out_valid), 0);
      @(posedge clk); #1;

      // R9: head locks, body holds, tail clears
      send(mk(2'b01, 16'hA0));
      @(negedge clk);
      check(link_locked == 1'b1, "R9", "lock after head", W'(link_locked), 1);
      @(posedge clk); #1;
      send(mk(2'b00, 16'hA1));
      send(mk(2'b00, 16'hA2));
      @(negedge clk);
      check(link_locked == 1'b1, "R9", "lock held over body", W'(link_locked), 1);
      @(posedge clk); #1;
      send(mk(2'b10, 16'hA3));
      @(negedge clk);
      check(link_locked == 1'b0, "R9", "lock cleared by tail", W'(link_locked), 0);
      // R4: four credits used
      check(in_ready == 1'b0, "R4", "ready after DEPTH sends", W'(in_ready), 0);
      @(posedge clk); #1;

      // R7 stall, R5 return
      fork
         send(mk(2'b11, 16'hB0));
         begin
            @(negedge clk);
            check(out_valid == 1'b0, "R7", "no forward at zero credit", W'(out_valid), 0);
            check(in_ready == 1'b0, "R7", "ready low at zero credit", W'(in_ready), 0);
            @(posedge clk); #1;
            pulse_credits(1);
            @(negedge clk);
            check(in_ready == 1'b1, "R5", "ready after return", W'(in_ready), 1);
            check(out_valid == 1'b1, "R5", "held flit forwarded", W'(out_valid), 1);
         end
      join
      @(negedge clk);
      check(link_locked == 1'b0, "R10", "single flit leaves lock clear", W'(link_locked), 0);
      check(in_ready == 1'b0, "R4", "credit used by single", W'(in_ready), 0);
      @(posedge clk); #1;

      // R8: refill and overfill
      pulse_credits(DEPTH + 2);
      send(mk(2'b01, 16'hC0));
      send(mk(2'b00, 16'hC1));
      send(mk(2'b00, 16'hC2));
      send(mk(2'b00, 16'hC3));
      @(negedge clk);
      check(in_ready == 1'b0, "R8", "excess returns ignored", W'(in_ready), 0);
      check(link_locked == 1'b1, "R9", "lock held mid packet", W'(link_locked), 1);
      @(posedge clk); #1;

      // R6: send and return together
      pulse_credits(1);
      credit_ret = 1'b1;
      in_valid = 1'b1;
      in_flit = mk(2'b10, 16'hC4);
      exp_q.push_back(in_flit);
      @(negedge clk);
      check(out_valid == 1'b1, "R6", "tail forwarded", W'(out_valid), 1);
      @(posedge clk); #1;
      in_valid = 1'b0;
      credit_ret = 1'b0;
      @(negedge clk);
      check(in_ready == 1'b1, "R6", "count kept on send+return", W'(in_ready), 1);
      check(link_locked == 1'b0, "R9", "lock cleared by tail", W'(link_locked), 0);
      @(posedge clk); #1;
      send(mk(2'b11, 16'hD0));
      @(negedge clk);
      check(in_ready == 1'b0, "R6", "one credit was left", W'(in_ready), 0);
      check(exp_q.size() == 0, "R2", "all flits delivered", W'(exp_q.size()), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule